// File: doc/BRIEF.md
# Three-Contestant Quiz Buzzer Controller

This block is the control core of a quiz buzzer for three contestants. A host works two slide switches, one that clears the game and one that opens answering. Each contestant has an active-low push button. The block cleans up each button in two steps. It passes the button through two synchronizing flip-flops, then accepts a new level only after it has held steady for a set number of clock cycles. While answering is open, the first contestant whose press arrives is locked in as the round winner and the other two are shut out.

A winning press adds one point to the winner's single-digit score. It starts a square-wave tone of about 100 Hz that lasts half a second, and it loads a countdown of ten seconds. The countdown is presented as two decimal digits. When it reaches zero, the lock is released and a new round can be won. All timing comes from the system clock through synchronous counters, scaled by a clock-frequency parameter. The block does not encode seven-segment patterns or multiplex digits.

Top module: `quizBuzzer`

## Requirements
- R1: A contestant press has no effect unless the start switch is on and the reset switch is off.
- R2: The first accepted press wins the round. `winnerNum` shows the winner as 1, 2 or 3 (button bit 0 is contestant 1), and shows 0 while no winner is locked.
- R3: While a round is locked, presses by any contestant change neither the winner nor any score.
- R4: When presses from several contestants are accepted in the same clock cycle, the lowest-numbered contestant wins.
- R5: Every score starts at 0. Each win adds one to the winner's score, and a score of 9 stays at 9.
- R6: A win drives `tone` as a square wave for CLK_HZ/2 cycles. The wave starts high and toggles every CLK_HZ/(2*TONE_HZ) cycles. Outside that window `tone` is 0.
- R7: A win loads the countdown with 10 (`cntTens`=1, `cntOnes`=0). It then steps down by one every CLK_HZ cycles. Values below 10 show `cntTens`=0 and the value on `cntOnes`.
- R8: When the countdown reaches 0, `winnerNum` returns to 0 and the next accepted press starts a new round.
- R9: While the reset switch is on, all scores, the winner number, the countdown and the tone are 0.
- R10: A button level that holds for fewer than DEB_CYCLES cycles after synchronization is not taken as a press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstSw | input | 1 | Reset switch, active high, sampled on the clock |
| startSw | input | 1 | Start switch, active high, answering open while on |
| btnN | input | 3 | Contestant buttons, active low, bit 0 is contestant 1 |
| winnerNum | output | 2 | Winning contestant 1..3, 0 when none |
| scoreP1 | output | 4 | Score of contestant 1, 0..9 |
| scoreP2 | output | 4 | Score of contestant 2, 0..9 |
| scoreP3 | output | 4 | Score of contestant 3, 0..9 |
| cntTens | output | 4 | Countdown tens digit, 0 or 1 |
| cntOnes | output | 4 | Countdown ones digit |
| tone | output | 1 | Low-frequency tone square wave |

## Verification
The bench uses small frequency parameters and applies these press patterns:
- single presses by each contestant, which check that the winner is identified correctly;
- presses made during a locked round, which show that the lock holds;
- two- and three-way presses in the same cycle, which check the priority order;
- a glitch shorter than the debounce time, which must not start a round;
- presses made with the start switch off.

Ten consecutive wins by one contestant show that the score saturates rather than wraps. Sampling the countdown halfway through each second checks every digit pair from 10 down to 0. A reset applied mid-round, followed by a fresh win, shows that everything clears and the block re-arms.

// File: rtl/quizPkg.sv
package quizPkg;
  localparam int PLAYERS = 3;
  localparam int SCORE_MAX = 9;
  localparam int COUNT_START = 10;

  typedef logic [1:0] playerNum_t;

  typedef struct packed {
    logic       win;
    playerNum_t who;
    logic       secTick;
    logic       endRound;
  } quizStrobe_t;
endpackage

// File: rtl/quizDebounce.sv
module quizDebounce #(
  parameter int DEB_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic btnN,
  output logic pressPulse
);
  localparam int CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEB_CYCLES - 1);

  logic syncA, syncB, levelQ;
  logic [CW-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      levelQ <= 1'b0;
      holdCnt <= '0;
      pressPulse <= 1'b0;
    end else begin
      syncA <= ~btnN;
      syncB <= syncA;
      pressPulse <= 1'b0;
      if (syncB != levelQ) begin
        if (holdCnt == LIMIT) begin
          levelQ <= syncB;
          holdCnt <= '0;
          pressPulse <= syncB;
        end else begin
          holdCnt <= holdCnt + 1'b1;
        end
      end else begin
        holdCnt <= '0;
      end
    end
  end

  // R10: a press is only reported once the new level has been accepted
  a_r10_press_after_hold: assert property (@(posedge clk) disable iff (rst)
    pressPulse |-> levelQ);
endmodule

// File: rtl/quizCtrl.sv
module quizCtrl
  import quizPkg::*;
#(
  parameter int CLK_HZ  = 50000000,
  parameter int TONE_HZ = 100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               startSw,
  input  logic [PLAYERS-1:0] press,
  input  logic               lastSec,
  output quizStrobe_t        str,
  output logic               tone
);
  localparam int HALF_SEC = CLK_HZ / 2;
  localparam int TONE_RAW = CLK_HZ / (2 * TONE_HZ);
  localparam int TONE_HALF = (TONE_RAW < 1) ? 1 : TONE_RAW;
  localparam int TW = $clog2(CLK_HZ);
  localparam int LW = $clog2(HALF_SEC + 1);
  localparam int HW = $clog2(TONE_HALF + 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(CLK_HZ - 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(TONE_HALF - 1);

  typedef enum logic {IDLE, LOCKED} state_t;

  state_t state;
  logic startA, startS;
  logic [TW-1:0] tickCnt;
  logic [LW-1:0] toneLeft;
  logic [HW-1:0] halfCnt;

  always_comb begin
    str = '0;
    if (press[0])      str.who = 2'd1;
    else if (press[1]) str.who = 2'd2;
    else               str.who = 2'd3;
    if (state == IDLE && startS && (|press)) str.win = 1'b1;
    if (state == LOCKED && tickCnt == TICK_LAST) begin
      str.secTick = 1'b1;
      str.endRound = lastSec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= IDLE;
      startA <= 1'b0;
      startS <= 1'b0;
      tickCnt <= '0;
      toneLeft <= '0;
      halfCnt <= '0;
      tone <= 1'b0;
    end else begin
      startA <= startSw;
      startS <= startA;
      if (str.win) begin
        state <= LOCKED;
        tickCnt <= '0;
      end else if (state == LOCKED) begin
        tickCnt <= (tickCnt == TICK_LAST) ? '0 : tickCnt + 1'b1;
        if (str.endRound) state <= IDLE;
      end
      if (str.win) begin
        toneLeft <= LW'(HALF_SEC);
        halfCnt <= '0;
        tone <= 1'b1;
      end else if (toneLeft != '0) begin
        toneLeft <= toneLeft - 1'b1;
        if (toneLeft == LW'(1)) begin
          tone <= 1'b0;
        end else if (halfCnt == HALF_LAST) begin
          halfCnt <= '0;
          tone <= ~tone;
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end else begin
        tone <= 1'b0;
      end
    end
  end

  // R1: no round may open while answering is closed
  a_r1_closed_no_win: assert property (@(posedge clk) disable iff (rst)
    !startS |-> !str.win);
  // R3: a locked round cannot be won again
  a_r3_locked_no_win: assert property (@(posedge clk) disable iff (rst)
    (state == LOCKED) |-> !str.win);
  // R6: tone is silent once its window has run out
  a_r6_tone_quiet: assert property (@(posedge clk) disable iff (rst)
    (toneLeft == '0 && !str.win) |=> !tone);
endmodule

// File: rtl/quizData.sv
module quizData
  import quizPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  quizStrobe_t str,
  output playerNum_t  winnerNum,
  output logic [3:0]  scoreQ [PLAYERS],
  output logic [3:0]  countQ,
  output logic        lastSec
);
  assign lastSec = (countQ == 4'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      winnerNum <= '0;
      countQ <= '0;
    end else begin
      if (str.win) begin
        winnerNum <= str.who;
        countQ <= 4'(COUNT_START);
      end else if (str.secTick && countQ != '0) begin
        countQ <= countQ - 4'd1;
      end
      if (str.endRound) winnerNum <= '0;
    end
  end

  for (genvar i = 0; i < PLAYERS; i++) begin : g_score
    always_ff @(posedge clk) begin
      if (rst) begin
        scoreQ[i] <= '0;
      end else if (str.win && str.who == 2'(i + 1) && scoreQ[i] != 4'(SCORE_MAX)) begin
        scoreQ[i] <= scoreQ[i] + 4'd1;
      end
    end

    // R5: a full score never wraps
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
      (scoreQ[i] == 4'(SCORE_MAX)) |=> (scoreQ[i] == 4'(SCORE_MAX)));
  end

  // R3: a locked winner is held until the round ends
  a_r3_winner_held: assert property (@(posedge clk) disable iff (rst)
    (winnerNum != '0 && !str.endRound) |=> $stable(winnerNum));
  // R7: countdown stays within its range
  a_r7_count_range: assert property (@(posedge clk) disable iff (rst)
    countQ <= 4'(COUNT_START));
  // R8: the round ends with the countdown at zero and no winner
  a_r8_end_clear: assert property (@(posedge clk) disable iff (rst)
    str.endRound |=> (countQ == '0 && winnerNum == '0));
endmodule

// File: rtl/quizBuzzer.sv
module quizBuzzer
  import quizPkg::*;
#(
  parameter int CLK_HZ     = 50000000,
  parameter int TONE_HZ    = 100,
  parameter int DEB_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstSw,
  input  logic       startSw,
  input  logic [2:0] btnN,
  output logic [1:0] winnerNum,
  output logic [3:0] scoreP1,
  output logic [3:0] scoreP2,
  output logic [3:0] scoreP3,
  output logic [3:0] cntTens,
  output logic [3:0] cntOnes,
  output logic       tone
);
  logic [PLAYERS-1:0] press;
  quizStrobe_t str;
  logic lastSec;
  logic [3:0] scoreQ [PLAYERS];
  logic [3:0] countQ;

  for (genvar i = 0; i < PLAYERS; i++) begin : g_btn
    quizDebounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk(clk), .rst(rstSw), .btnN(btnN[i]), .pressPulse(press[i]));
  end

  quizCtrl #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ)) u_ctrl (
    .clk(clk), .rst(rstSw), .startSw(startSw), .press(press),
    .lastSec(lastSec), .str(str), .tone(tone));

  quizData u_data (
    .clk(clk), .rst(rstSw), .str(str), .winnerNum(winnerNum),
    .scoreQ(scoreQ), .countQ(countQ), .lastSec(lastSec));

  assign scoreP1 = scoreQ[0];
  assign scoreP2 = scoreQ[1];
  assign scoreP3 = scoreQ[2];
  assign cntTens = (countQ == 4'(COUNT_START)) ? 4'd1 : 4'd0;
  assign cntOnes = (countQ == 4'(COUNT_START)) ? 4'd0 : countQ;
endmodule

// File: tb/quizBuzzer_bench.sv
module quizBuzzer_bench;
  localparam int PERIOD = 10;
  localparam int HZ = 200;
  localparam int THZ = 10;
  localparam int DEB = 4;

  logic clk = 1'b0;
  logic rstSw = 1'b1;
  logic startSw = 1'b0;
  logic [2:0] btnN = 3'b111;
  logic [1:0] winnerNum;
  logic [3:0] scoreP1, scoreP2, scoreP3, cntTens, cntOnes;
  logic tone;

  int cyc = 0;
  int toneHigh = 0;
  int checks = 0;
  int fails = 0;
  int expScore [3] = '{0, 0, 0};
  bit done = 1'b0;

  quizBuzzer #(.CLK_HZ(HZ), .TONE_HZ(THZ), .DEB_CYCLES(DEB)) u_quizBuzzer (
    .clk(clk), .rstSw(rstSw), .startSw(startSw), .btnN(btnN),
    .winnerNum(winnerNum), .scoreP1(scoreP1), .scoreP2(scoreP2),
    .scoreP3(scoreP3), .cntTens(cntTens), .cntOnes(cntOnes), .tone(tone));

  always #(PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (tone) toneHigh <= toneHigh + 1;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic waitTo(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic chkScores(string req);
    chk(req, scoreP1, expScore[0]);
    chk(req, scoreP2, expScore[1]);
    chk(req, scoreP3, expScore[2]);
  endtask

  // press the buttons in mask together; returns the cycle the win appeared
  task automatic pressWin(logic [2:0] mask, output int w);
    w = -1;
    btnN = ~mask;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (i == 10) btnN = 3'b111;
      if (w < 0 && winnerNum != 0) w = cyc;
    end
    btnN = 3'b111;
  endtask

  task automatic fullRound(logic [2:0] mask, int expWin, string req);
    int w;
    pressWin(mask, w);
    chk(req, (w >= 0) ? 1 : 0, 1);
    chk(req, winnerNum, expWin);
    expScore[expWin-1] = (expScore[expWin-1] < 9) ? expScore[expWin-1] + 1 : 9;
    chkScores("R5");
    waitTo(w + 10 * HZ + HZ / 2);
    chk("R8", winnerNum, 0);
  endtask

  initial begin
    int w;
    repeat (5) @(negedge clk);
    // R9 reset state
    chk("R9", winnerNum, 0);
    chk("R9", cntTens * 10 + cntOnes, 0);
    chk("R9", tone, 0);
    chkScores("R9");
    rstSw = 1'b0;
    repeat (5) @(negedge clk);

    // R1: start switch off, press ignored
    pressWin(3'b001, w);
    chk("R1", winnerNum, 0);
    chkScores("R1");

    startSw = 1'b1;
    repeat (5) @(negedge clk);
    // R10: glitch shorter than the debounce time
    btnN = 3'b110;
    repeat (2) @(negedge clk);
    btnN = 3'b111;
    repeat (40) @(negedge clk);
    chk("R10", winnerNum, 0);
    chkScores("R10");

    // R2/R7/R6/R3: one detailed round, contestant 2 wins
    toneHigh = 0;
    pressWin(3'b010, w);
    chk("R2", winnerNum, 2);
    expScore[1] = 1;
    chkScores("R5");
    for (int k = 0; k <= 10; k++) begin
      waitTo(w + k * HZ + HZ / 2);
      chk("R7", cntTens * 10 + cntOnes, 10 - k);
      chk("R7", cntTens, (k == 0) ? 1 : 0);
      if (k == 1) begin
        int w2;
        pressWin(3'b101, w2);
        chk("R3", winnerNum, 2);
        chkScores("R3");
      end
    end
    chk("R8", winnerNum, 0);
    chk("R6", toneHigh, HZ / 4);
    chk("R6", tone, 0);

    // R4: simultaneous presses
    fullRound(3'b110, 2, "R4");
    fullRound(3'b111, 1, "R4");
    // R5: saturation by ten wins of contestant 3
    for (int n = 0; n < 10; n++) fullRound(3'b100, 3, "R5");
    chk("R5", scoreP3, 9);

    // R9: reset in the middle of a round, then re-arm
    pressWin(3'b001, w);
    waitTo(w + 300);
    rstSw = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", winnerNum, 0);
    chk("R9", cntTens * 10 + cntOnes, 0);
    chk("R9", tone, 0);
    expScore = '{0, 0, 0};
    chkScores("R9");
    rstSw = 1'b0;
    repeat (5) @(negedge clk);
    pressWin(3'b010, w);
    chk("R8", winnerNum, 2);
    chk("R5", scoreP2, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule